// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the state machine that paces a 16-bit multicycle processor. The datapath places the 4-bit opcode held in its instruction register on the `opcode` input. The sequencer walks through an instruction fetch step and a decode/register-read step. It then follows the execute path for the instruction's class and returns to fetch.

In every cycle it drives one 17-bit control word to the datapath. The word holds these fields:

- the write-register select
- the register-file write enable
- the two ALU operand selects
- the memory read and write strobes
- the memory-to-register select
- the instruction-or-data address select
- the instruction register load
- the unconditional and conditional PC loads
- the ALU operation class
- the next-PC source

Opcode 15 sends the sequencer to a parked state. There it drives no enables and waits for reset.

The control word is a pure function of the current state, so it changes only at clock edges. A parameter chooses how the word is produced. It can be decoded from the state register, or it can be held in its own flop that is loaded from the next-state value. The two forms have identical port timing. The 4-bit current state and a halt flag are also brought out for the datapath.

Top module: `mcs_sequencer`

## Requirements
- R1: With `rst_n` low at a clock edge, the state becomes 0 (fetch) and the control word becomes the fetch word of R9.
- R2: State 0 is always followed by state 1, whatever the opcode.
- R3: In state 1 the opcode selects the next state:
  - opcodes 0 to 4 and 10 go to state 6;
  - opcodes 5 and 11 go to state 10;
  - opcodes 6 and 7 go to state 2;
  - opcodes 8 and 9 go to state 8;
  - opcode 12 goes to state 9;
  - opcode 13 goes to state 12;
  - opcode 14 goes to state 13;
  - opcode 15 goes to state 15.
- R4: State 2 goes to state 3 when the opcode is 6 and to state 5 when it is 7. State 3 goes to state 4. States 4 and 5 go to state 0.
- R5: Register ALU ops run state 6 and then state 7. Immediate ALU ops run state 10 and then state 11. Both paths then return to 0.
- R6: States 8, 9 and 12 go to state 0 after one cycle. State 13 goes to state 14, and state 14 goes to state 0.
- R7: Once in state 15, the sequencer stays there with `halted` high until reset. Opcode changes have no effect while halted.
- R8: In state 15 the control word is all zero.
- R9: The control word fields sit at these bit positions:
  - write-register select [16:15]
  - register write [14]
  - ALU A select [13]
  - memory read [12]
  - memory write [11]
  - memory-to-register [10]
  - address select [9]
  - IR load [8]
  - PC load [7]
  - conditional PC load [6]
  - ALU class [5:4]
  - ALU B select [3:2]
  - PC source [1:0]

  The fetch word sets memory read, IR load and PC load, with B select 01. The decode word sets only B select 11.
- R10: The ALU class field is 01 (follow opcode) in states 6, 8 and 10, and 00 (add) in every other state.
- R11: The execute words are as follows, with all fields not named at zero:
  - state 2: A=1, B=10
  - state 3: memory read, address select
  - state 4: register write, memory-to-register
  - state 5: memory write, address select
  - state 6: A=1
  - state 7: write-register select 01, register write
  - state 8: A=1, conditional PC load, PC source 01
  - state 9: PC load, PC source 10
  - state 10: A=1, B=10
  - state 11: register write
  - state 12: PC load, PC source 11
  - state 13: PC load, PC source 10
  - state 14: write-register select 10, register write

  The IR load is set only in state 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 4 | Opcode field of the instruction register |
| ctrl_word | output | 17 | Datapath control word for the current cycle |
| seq_state | output | 4 | Current sequencer state number |
| halted | output | 1 | High while parked in the halt state |

## Verification
A wrong transition shows on `seq_state` at the very next edge. A wrong word entry shows on `ctrl_word` in the same cycle the faulty state is entered, because the word follows the state without delay. A dispatch error is caught one cycle after decode, when the execute state appears. A stuck or leaky halt is caught within one cycle of an opcode change while parked. The bench drives every opcode through its full path and compares both outputs against its own model at every clock. As a result, no mistake can hide for longer than a single cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   localparam int STATE_W = 4;
   localparam int CTRL_W  = 17;

   typedef enum logic [STATE_W-1:0] {
      ST_FETCH     = 4'd0,
      ST_DECODE    = 4'd1,
      ST_MEM_ADDR  = 4'd2,
      ST_MEM_LOAD  = 4'd3,
      ST_LOAD_WB   = 4'd4,
      ST_MEM_STORE = 4'd5,
      ST_RR_EXEC   = 4'd6,
      ST_RR_WB     = 4'd7,
      ST_BRANCH    = 4'd8,
      ST_JUMP      = 4'd9,
      ST_IMM_EXEC  = 4'd10,
      ST_IMM_WB    = 4'd11,
      ST_JREG      = 4'd12,
      ST_JLINK_PC  = 4'd13,
      ST_JLINK_WB  = 4'd14,
      ST_HALT      = 4'd15
   } seq_state_e;

   typedef struct packed {
      logic [1:0] wr_sel;
      logic       reg_wr;
      logic       alu_a;
      logic       mem_rd;
      logic       mem_wr;
      logic       mem_to_reg;
      logic       addr_sel;
      logic       ir_ld;
      logic       pc_ld;
      logic       pc_ld_cond;
      logic [1:0] alu_class;
      logic [1:0] alu_b;
      logic [1:0] pc_src;
   } ctl_word_t;

   localparam logic [1:0] ALU_ADD    = 2'b00;
   localparam logic [1:0] ALU_BY_OPC = 2'b01;

endpackage

// File: rtl/mcs_dispatch.sv
module mcs_dispatch
   import mcs_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  seq_state_e       cur,
   input  logic [OPC_W-1:0] opcode,
   output seq_state_e       nxt
);

   localparam logic [OPC_W-1:0] OP_STORE = OPC_W'(7);

   seq_state_e from_decode;

   always_comb begin
      case (opcode)
         OPC_W'(0), OPC_W'(1), OPC_W'(2),
         OPC_W'(3), OPC_W'(4), OPC_W'(10): from_decode = ST_RR_EXEC;
         OPC_W'(5), OPC_W'(11):            from_decode = ST_IMM_EXEC;
         OPC_W'(6), OPC_W'(7):             from_decode = ST_MEM_ADDR;
         OPC_W'(8), OPC_W'(9):             from_decode = ST_BRANCH;
         OPC_W'(12):                       from_decode = ST_JUMP;
         OPC_W'(13):                       from_decode = ST_JREG;
         OPC_W'(14):                       from_decode = ST_JLINK_PC;
         default:                          from_decode = ST_HALT;
      endcase
   end

   always_comb begin
      case (cur)
         ST_FETCH:    nxt = ST_DECODE;
         ST_DECODE:   nxt = from_decode;
         ST_MEM_ADDR: nxt = (opcode == OP_STORE) ? ST_MEM_STORE : ST_MEM_LOAD;
         ST_MEM_LOAD: nxt = ST_LOAD_WB;
         ST_RR_EXEC:  nxt = ST_RR_WB;
         ST_IMM_EXEC: nxt = ST_IMM_WB;
         ST_JLINK_PC: nxt = ST_JLINK_WB;
         ST_HALT:     nxt = ST_HALT;
         default:     nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcs_word_rom.sv
module mcs_word_rom
   import mcs_pkg::*;
(
   input  seq_state_e st,
   output ctl_word_t  word
);

   always_comb begin
      word = '0;
      case (st)
         ST_FETCH: begin
            word.mem_rd = 1'b1;
            word.ir_ld  = 1'b1;
            word.pc_ld  = 1'b1;
            word.alu_b  = 2'b01;
         end
         ST_DECODE:   word.alu_b = 2'b11;
         ST_MEM_ADDR: begin
            word.alu_a = 1'b1;
            word.alu_b = 2'b10;
         end
         ST_MEM_LOAD: begin
            word.mem_rd   = 1'b1;
            word.addr_sel = 1'b1;
         end
         ST_LOAD_WB: begin
            word.reg_wr     = 1'b1;
            word.mem_to_reg = 1'b1;
         end
         ST_MEM_STORE: begin
            word.mem_wr   = 1'b1;
            word.addr_sel = 1'b1;
         end
         ST_RR_EXEC: begin
            word.alu_a     = 1'b1;
            word.alu_class = ALU_BY_OPC;
         end
         ST_RR_WB: begin
            word.wr_sel = 2'b01;
            word.reg_wr = 1'b1;
         end
         ST_BRANCH: begin
            word.alu_a      = 1'b1;
            word.alu_class  = ALU_BY_OPC;
            word.pc_ld_cond = 1'b1;
            word.pc_src     = 2'b01;
         end
         ST_JUMP, ST_JLINK_PC: begin
            word.pc_ld  = 1'b1;
            word.pc_src = 2'b10;
         end
         ST_IMM_EXEC: begin
            word.alu_a     = 1'b1;
            word.alu_class = ALU_BY_OPC;
            word.alu_b     = 2'b10;
         end
         ST_IMM_WB: word.reg_wr = 1'b1;
         ST_JREG: begin
            word.pc_ld  = 1'b1;
            word.pc_src = 2'b11;
         end
         ST_JLINK_WB: begin
            word.wr_sel = 2'b10;
            word.reg_wr = 1'b1;
         end
         default: word = '0;
      endcase
   end

endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
   import mcs_pkg::*;
#(
   parameter int OPC_W    = 4,
   parameter bit REG_WORD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OPC_W-1:0]   opcode,
   output logic [CTRL_W-1:0]  ctrl_word,
   output logic [STATE_W-1:0] seq_state,
   output logic               halted
);

   localparam int OPC_COUNT = 1 << OPC_W;

   if (OPC_COUNT != 16) begin : g_bad_opc_w
      $error("mcs_sequencer: OPC_W must give exactly 16 opcodes");
   end
   if ($bits(ctl_word_t) != CTRL_W) begin : g_bad_word_w
      $error("mcs_sequencer: control word layout width mismatch");
   end

   seq_state_e state_q, state_d;
   ctl_word_t  cw_out;

   mcs_dispatch #(.OPC_W(OPC_W)) u_dispatch (
      .cur    (state_q),
      .opcode (opcode),
      .nxt    (state_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_FETCH;
      else        state_q <= state_d;
   end

   if (REG_WORD) begin : g_word_reg
      seq_state_e rom_in;
      ctl_word_t  rom_out;
      ctl_word_t  word_q;
      assign rom_in = rst_n ? state_d : ST_FETCH;
      mcs_word_rom u_rom (.st(rom_in), .word(rom_out));
      always_ff @(posedge clk) word_q <= rom_out;
      assign cw_out = word_q;
   end else begin : g_word_comb
      mcs_word_rom u_rom (.st(state_q), .word(cw_out));
   end

   assign ctrl_word = cw_out;
   assign seq_state = state_q;
   assign halted    = (state_q == ST_HALT);

   assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_FETCH |=> state_q == ST_DECODE);

   assert_rr_then_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_RR_EXEC |=> state_q == ST_RR_WB);

   assert_jlink_then_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_JLINK_PC |=> state_q == ST_JLINK_WB);

   assert_short_paths_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q inside {ST_BRANCH, ST_JUMP, ST_JREG, ST_JLINK_WB, ST_LOAD_WB,
                       ST_MEM_STORE, ST_RR_WB, ST_IMM_WB}) |=> state_q == ST_FETCH);

   assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> ctrl_word == '0);

   assert_alu_class_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cw_out.alu_class != ALU_ADD |-> (state_q inside {ST_RR_EXEC, ST_BRANCH, ST_IMM_EXEC}));

   assert_ir_load_fetch_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cw_out.ir_ld |-> state_q == ST_FETCH);

endmodule

// File: tb/tb_mcs_sequencer.sv
module tb_mcs_sequencer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  opcode = 4'd0;
   logic [16:0] ctrl_word;
   logic [3:0]  seq_state;
   logic        halted;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int st = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   mcs_sequencer dut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode),
      .ctrl_word(ctrl_word), .seq_state(seq_state), .halted(halted)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [16:0] mk(int rd, int rw, int a, int mr, int mw, int m2r,
                                      int ad, int ir, int pw, int pwc, int cls, int b, int ps);
      int v;
      v = (rd << 15) | (rw << 14) | (a << 13) | (mr << 12) | (mw << 11) | (m2r << 10)
        | (ad << 9) | (ir << 8) | (pw << 7) | (pwc << 6) | (cls << 4) | (b << 2) | ps;
      return v[16:0];
   endfunction

   function automatic logic [16:0] exp_word(int s);
      case (s)
         0:  return mk(0,0,0,1,0,0,0,1,1,0,0,1,0);
         1:  return mk(0,0,0,0,0,0,0,0,0,0,0,3,0);
         2:  return mk(0,0,1,0,0,0,0,0,0,0,0,2,0);
         3:  return mk(0,0,0,1,0,0,1,0,0,0,0,0,0);
         4:  return mk(0,1,0,0,0,1,0,0,0,0,0,0,0);
         5:  return mk(0,0,0,0,1,0,1,0,0,0,0,0,0);
         6:  return mk(0,0,1,0,0,0,0,0,0,0,1,0,0);
         7:  return mk(1,1,0,0,0,0,0,0,0,0,0,0,0);
         8:  return mk(0,0,1,0,0,0,0,0,0,1,1,0,1);
         9:  return mk(0,0,0,0,0,0,0,0,1,0,0,0,2);
         10: return mk(0,0,1,0,0,0,0,0,0,0,1,2,0);
         11: return mk(0,1,0,0,0,0,0,0,0,0,0,0,0);
         12: return mk(0,0,0,0,0,0,0,0,1,0,0,0,3);
         13: return mk(0,0,0,0,0,0,0,0,1,0,0,0,2);
         14: return mk(2,1,0,0,0,0,0,0,0,0,0,0,0);
         default: return 17'd0;
      endcase
   endfunction

   function automatic int model_next(int s, int op);
      case (s)
         0: return 1;
         1: begin
            if (op <= 4 || op == 10) return 6;
            if (op == 5 || op == 11) return 10;
            if (op == 6 || op == 7) return 2;
            if (op == 8 || op == 9) return 8;
            if (op == 12) return 9;
            if (op == 13) return 12;
            if (op == 14) return 13;
            return 15;
         end
         2: return (op == 7) ? 5 : 3;
         3: return 4;
         6: return 7;
         10: return 11;
         13: return 14;
         15: return 15;
         default: return 0;
      endcase
   endfunction

   function automatic string state_tag(int s);
      case (s)
         0: return "R2";
         1: return "R3";
         2, 3, 4, 5: return "R4";
         6, 7, 10, 11: return "R5";
         15: return "R7";
         default: return "R6";
      endcase
   endfunction

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   int prev_st = 0;

   always @(posedge clk) begin
      cyc++;
      prev_st = st;
      if (!rst_n) st = 0;
      else st = model_next(st, opcode);
      started = 1'b1;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
         report();
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         logic [16:0] ew;
         string t;
         ew = exp_word(st);
         checks++;
         if (seq_state !== st[3:0]) begin
            errors++;
            t = rst_n ? state_tag(prev_st) : "R1";
            $display("FAIL %s: state actual %0d expected %0d", t, seq_state, st);
         end
         checks++;
         if (ctrl_word !== ew) begin
            errors++;
            if (st == 15) t = "R8";
            else if (ctrl_word[5:4] !== ew[5:4]) t = "R10";
            else if (st <= 1) t = "R9";
            else t = "R11";
            $display("FAIL %s: word in state %0d actual %h expected %h", t, st, ctrl_word, ew);
         end
         checks++;
         if (halted !== (st == 15)) begin
            errors++;
            $display("FAIL R7: halted actual %0b expected %0b", halted, st == 15);
         end
      end
   end

   task automatic run_instr(int op);
      @(negedge clk);
      while (st != 0) @(negedge clk);
      opcode = op[3:0];
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (st == 0 || st == 15) break;
      end
   endtask

   task automatic check_reset_state();
      checks++;
      if (seq_state !== 4'd0 || ctrl_word !== exp_word(0) || halted !== 1'b0) begin
         errors++;
         $display("FAIL R1: after reset state %0d word %h, expected state 0 word %h",
                  seq_state, ctrl_word, exp_word(0));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      // R3 R4 R5 R6: every opcode through its full path
      for (int op = 0; op < 15; op++) run_instr(op);
      run_instr(3); run_instr(7); run_instr(6); run_instr(9);
      run_instr(14); run_instr(11); run_instr(8); run_instr(0);
      run_instr(13); run_instr(12); run_instr(10); run_instr(5);
      // R1: reset in the middle of a register-ALU instruction
      @(negedge clk);
      while (st != 0) @(negedge clk);
      opcode = 4'd2;
      while (st != 6) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      run_instr(4);
      // R7 R8: halt, then toggle opcode while parked
      run_instr(15);
      for (int k = 0; k < 12; k++) begin
         opcode = k[3:0];
         @(negedge clk);
      end
      checks++;
      if (seq_state !== 4'd15 || halted !== 1'b1 || ctrl_word !== 17'd0) begin
         errors++;
         $display("FAIL R7: parked state %0d halted %0b word %h, expected 15 1 00000",
                  seq_state, halted, ctrl_word);
      end
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      run_instr(6);
      run_instr(14);
      done = 1'b1;
      report();
   end

endmodule